// File: doc/BRIEF.md
# PHY Management Frame Master

This block runs single register transactions on a two-wire PHY management bus. It follows the Clause 22 frame layout. A host presents a request with a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then drives a management clock and a bidirectional data line through one complete frame. When the frame is over it returns a one-cycle completion pulse. After a read, the 16-bit value returned by the PHY is available at that point.

The management clock comes from the system clock. Its half-period, in system cycles, is set by a parameter. The data pad is presented as three separate signals: an output value, an output enable and a raw input. The raw input passes through a small synchronizer before it is used, and the read sampling point is moved later by the synchronizer depth so that it still captures the line value present at each falling clock edge. Requests are taken only while the block is idle. A busy flag covers the whole transaction.

Top module: `mgmt_frame_master`

## Requirements
- R1: After reset, `mgmt_clk` is 0, `mgmt_oe` is 1, `mgmt_out` is 1, `busy` and `done` are 0 and `rd_data` is 0.
- R2: During a frame, each management clock cycle lasts exactly 2*HALF_DIV system cycles, with HALF_DIV high and HALF_DIV low. Between frames the clock stays low.
- R3: A frame opens with 32 clock cycles in which the data line is driven to 1.
- R4: Next comes a 4-bit start/operation field: 0110 for a read (`req_rd`=1) and 0101 for a write. It is followed by the 5-bit PHY address and then the 5-bit register address. All fields are sent most significant bit first.
- R5: A write then drives turnaround bits 1,0, the 16 data bits most significant bit first, and one final clock with the line driven to 1. That is 65 clock cycles in all.
- R6: A read releases the line (`mgmt_oe`=0) for one turnaround clock and 16 data clocks, then re-drives it to 1 for one final clock. That is 64 clock cycles in all. The output enable is never low outside a read.
- R7: For a read, `rd_data[15]` holds the line value present at the falling clock edge that ends the first data clock. Each later bit follows in order, down to `rd_data[0]`. The value is valid when `done` pulses.
- R8: The data line value and its enable change only while the management clock is low.
- R9: `busy` is 1 from the cycle after a request is accepted until the cycle in which `done` is 1. `done` lasts one cycle. A request made while `busy` is 1 is ignored: the running frame is not changed and no second frame follows.
- R10: A write frame leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, accepted only while idle |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data captured by the last read |
| mgmt_clk | output | 1 | Management clock |
| mgmt_out | output | 1 | Data line output value |
| mgmt_oe | output | 1 | Data line output enable |
| mgmt_in | input | 1 | Raw data line input |

## Verification
The hardest situation to reach is a read in which the returned bits line up exactly with the sampling points, which fall after the synchronizer delay. A bench-side PHY model counts the management clock rising edges. It presents each read bit only after the rising edge of its own data clock and holds it until the next rising edge, so any error in slot counting or in the sample offset shifts the captured word. A request issued partway through a frame, carrying different fields, exercises the rule that requests arriving while busy are ignored.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int PRE_LEN  = 32;
  localparam int OP_LEN   = 4;
  localparam int PHY_W    = 5;
  localparam int REG_W    = 5;
  localparam int DATA_W   = 16;
  localparam int HDR_END  = PRE_LEN + OP_LEN + PHY_W + REG_W;   // first turnaround slot
  localparam int WR_LAST  = HDR_END + 2 + DATA_W;              // final idle slot of a write
  localparam int RD_LAST  = HDR_END + 1 + DATA_W;              // final idle slot of a read
  localparam int RD_SAMP0 = HDR_END + 2;                       // slot holding first read sample
  localparam int SLOT_W   = $clog2(WR_LAST + 1);
  localparam logic [OP_LEN-1:0] OP_READ  = 4'b0110;
  localparam logic [OP_LEN-1:0] OP_WRITE = 4'b0101;
endpackage

// File: rtl/mgmt_half_div.sv
module mgmt_half_div #(
  parameter int HALF = 20,
  localparam int CW = $clog2(HALF + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [CW-1:0] cnt,
  output logic          half_end
);
  assign half_end = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || half_end) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mgmt_in_sync.sv
module mgmt_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_st
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mgmt_frame_bit.sv
module mgmt_frame_bit
  import mgmt_pkg::*;
(
  input  logic [SLOT_W-1:0] slot,
  input  logic              is_rd,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  rg,
  input  logic [DATA_W-1:0] wdata,
  output logic              drv,
  output logic              val
);
  logic [OP_LEN-1:0] op_v;
  int s;

  always_comb begin
    op_v = is_rd ? OP_READ : OP_WRITE;
    s    = int'(slot);
    drv  = 1'b1;
    val  = 1'b1;
    if (s < PRE_LEN) begin
      val = 1'b1;
    end else if (s < PRE_LEN + OP_LEN) begin
      val = 1'(op_v >> (PRE_LEN + OP_LEN - 1 - s));
    end else if (s < PRE_LEN + OP_LEN + PHY_W) begin
      val = 1'(phy >> (PRE_LEN + OP_LEN + PHY_W - 1 - s));
    end else if (s < HDR_END) begin
      val = 1'(rg >> (HDR_END - 1 - s));
    end else if (is_rd) begin
      drv = (s >= RD_LAST);
      val = 1'b1;
    end else if (s == HDR_END) begin
      val = 1'b1;
    end else if (s == HDR_END + 1) begin
      val = 1'b0;
    end else if (s < WR_LAST) begin
      val = 1'(wdata >> (WR_LAST - 1 - s));
    end else begin
      val = 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
  import mgmt_pkg::*;
#(
  parameter int HALF_DIV    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        req_rd,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mgmt_clk,
  output logic        mgmt_out,
  output logic        mgmt_oe,
  input  logic        mgmt_in
);
  localparam int CW = $clog2(HALF_DIV + 1);

  logic              rd_q;
  logic [PHY_W-1:0]  phy_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] wd_q;
  logic [SLOT_W-1:0] slot;
  logic              phase;      // 0 = clock low half, 1 = clock high half
  logic [CW-1:0]     cnt;
  logic              half_end;
  logic              in_s;
  logic              nx_drv, nx_val;
  logic [SLOT_W-1:0] slot_nx;
  logic [SLOT_W-1:0] last_slot;
  logic              sample_now;

  mgmt_half_div #(.HALF(HALF_DIV)) u_div (
    .clk(clk), .rst(rst), .run(busy), .cnt(cnt), .half_end(half_end)
  );

  mgmt_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(mgmt_in), .q(in_s)
  );

  assign slot_nx = slot + 1'b1;

  mgmt_frame_bit u_bit (
    .slot(slot_nx), .is_rd(rd_q), .phy(phy_q), .rg(reg_q), .wdata(wd_q),
    .drv(nx_drv), .val(nx_val)
  );

  assign last_slot  = rd_q ? SLOT_W'(RD_LAST) : SLOT_W'(WR_LAST);
  // sample point sits SYNC_STAGES cycles after the falling edge that closes a data slot
  assign sample_now = busy && rd_q && !phase && (cnt == CW'(SYNC_STAGES)) &&
                      (slot >= SLOT_W'(RD_SAMP0)) && (slot <= SLOT_W'(RD_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      rd_data  <= '0;
      mgmt_clk <= 1'b0;
      mgmt_out <= 1'b1;
      mgmt_oe  <= 1'b1;
      rd_q     <= 1'b0;
      phy_q    <= '0;
      reg_q    <= '0;
      wd_q     <= '0;
      slot     <= '0;
      phase    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy     <= 1'b1;
          rd_q     <= req_rd;
          phy_q    <= req_phy;
          reg_q    <= req_reg;
          wd_q     <= req_wdata;
          slot     <= '0;
          phase    <= 1'b0;
          mgmt_out <= 1'b1;
          mgmt_oe  <= 1'b1;
        end
      end else begin
        if (sample_now) rd_data <= {rd_data[DATA_W-2:0], in_s};
        if (half_end) begin
          if (!phase) begin
            mgmt_clk <= 1'b1;
            phase    <= 1'b1;
          end else begin
            mgmt_clk <= 1'b0;
            phase    <= 1'b0;
            if (slot == last_slot) begin
              busy     <= 1'b0;
              done     <= 1'b1;
              mgmt_out <= 1'b1;
              mgmt_oe  <= 1'b1;
            end else begin
              slot     <= slot_nx;
              mgmt_out <= nx_val;
              mgmt_oe  <= nx_drv;
            end
          end
        end
      end
    end
  end

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mgmt_clk); // R2
  AST_LINE_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (mgmt_clk && $past(mgmt_clk)) |-> ($stable(mgmt_out) && $stable(mgmt_oe))); // R8
  AST_RELEASE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !mgmt_oe |-> (busy && rd_q)); // R6
  AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (rst)
    (busy && slot < SLOT_W'(PRE_LEN)) |-> (mgmt_oe && mgmt_out)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R9
  AST_WRITE_KEEPS_RD: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_q) |=> $stable(rd_data)); // R10
endmodule

// File: tb/sim_mgmt_frame_master.sv
module sim_mgmt_frame_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_rd = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, mgmt_clk, mgmt_out, mgmt_oe;
  logic [15:0] rd_data;
  logic        mgmt_in = 1'b1;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // capture of the frame seen on each rising management clock edge
  logic cap_o  [0:127];
  logic cap_oe [0:127];
  int   rise_n = 0;
  int   hi_len = 0;
  int   lo_len = 0;
  int   tmg_bad = 0;
  logic prev_clk = 1'b0;
  logic [15:0] phy_word = '0;
  logic phy_rd_mode = 1'b0;

  mgmt_frame_master #(.HALF_DIV(HALF), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .req(req), .req_rd(req_rd), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .mgmt_clk(mgmt_clk), .mgmt_out(mgmt_out),
    .mgmt_oe(mgmt_oe), .mgmt_in(mgmt_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus monitor and PHY model, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (mgmt_clk && !prev_clk) begin
      if (rise_n < 128) begin
        cap_o[rise_n]  = mgmt_out;
        cap_oe[rise_n] = mgmt_oe;
      end
      if (rise_n > 0 && lo_len != HALF) tmg_bad++;
      if (phy_rd_mode && rise_n >= 47 && rise_n <= 62) mgmt_in = phy_word[62 - rise_n];
      else mgmt_in = 1'b1;
      rise_n++;
    end
    if (!mgmt_clk && prev_clk && hi_len != HALF) tmg_bad++;
    if (mgmt_clk) begin hi_len++; lo_len = 0; end
    else begin lo_len++; if (!prev_clk) hi_len = hi_len; else hi_len = 0; end
    prev_clk = mgmt_clk;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [1:0] exp_bit(int i, bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] w);
    logic [3:0] op;
    op = rd ? 4'b0110 : 4'b0101;
    if (i < 32) return 2'b11;
    if (i < 36) return {1'b1, op[35 - i]};
    if (i < 41) return {1'b1, p[40 - i]};
    if (i < 46) return {1'b1, r[45 - i]};
    if (rd) return (i < 63) ? 2'b00 : 2'b11;
    if (i == 46) return 2'b11;
    if (i == 47) return 2'b10;
    if (i < 64) return {1'b1, w[63 - i]};
    return 2'b11;
  endfunction

  task automatic run_frame(input bit rd, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] w, input logic [15:0] pw, input bit poke);
    int t;
    int bad_pre, bad_hdr, bad_tail;
    logic [15:0] rd_before;
    logic [1:0] e;
    rd_before = rd_data;
    rise_n = 0; tmg_bad = 0;
    phy_word = pw; phy_rd_mode = rd;
    @(negedge clk);
    req = 1'b1; req_rd = rd; req_phy = p; req_reg = r; req_wdata = w;
    @(negedge clk);
    req = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", busy, 1);
    t = 0;
    while (done !== 1'b1 && t < 2000) begin
      @(negedge clk);
      t++;
      if (poke && t == 100) begin
        req = 1'b1; req_rd = !rd; req_phy = ~p; req_reg = ~r; req_wdata = ~w;
      end
      if (poke && t == 101) req = 1'b0;
      if (done !== 1'b1 && busy !== 1'b1) t = 2000;
    end
    chk(done === 1'b1, "R9 done reached with busy held", done, 1);
    chk(busy === 1'b0, "R9 busy low at done", busy, 0);
    chk(rise_n == (rd ? 64 : 65), rd ? "R6 read clock count" : "R5 write clock count",
        rise_n, rd ? 64 : 65);
    chk(tmg_bad == 0, "R2 clock half widths", tmg_bad, 0);
    bad_pre = 0; bad_hdr = 0; bad_tail = 0;
    for (int i = 0; i < rise_n && i < 128; i++) begin
      e = exp_bit(i, rd, p, r, w);
      if (cap_oe[i] !== e[1] || (e[1] && cap_o[i] !== e[0])) begin
        if (i < 32) bad_pre++;
        else if (i < 46) bad_hdr++;
        else bad_tail++;
      end
    end
    chk(bad_pre == 0, "R3 preamble bits", bad_pre, 0);
    chk(bad_hdr == 0, "R4 opcode and address bits", bad_hdr, 0);
    chk(bad_tail == 0, rd ? "R6 read release and idle" : "R5 turnaround data idle", bad_tail, 0);
    if (rd) chk(rd_data === pw, "R7 read data", rd_data, pw);
    else    chk(rd_data === rd_before, "R10 write keeps read data", rd_data, rd_before);
    @(negedge clk);
    chk(done === 1'b0, "R9 done single cycle", done, 0);
    if (poke) begin
      for (int k = 0; k < 3 * HALF; k++) @(negedge clk);
      chk(busy === 1'b0 && mgmt_clk === 1'b0, "R9 request while busy ignored",
          {busy, mgmt_clk}, 0);
    end
    chk(mgmt_clk === 1'b0 && mgmt_oe === 1'b1, "R2 idle clock low, line driven",
        {mgmt_clk, mgmt_oe}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mgmt_clk === 1'b0 && mgmt_oe === 1'b1 && mgmt_out === 1'b1 &&
        busy === 1'b0 && done === 1'b0 && rd_data === 16'h0, "R1 reset state",
        {mgmt_clk, mgmt_oe, mgmt_out, busy, done}, 5'b01100);
    for (int i = 0; i < 8; i++) begin
      run_frame(1'b1, 5'(i * 7 + 3), 5'(31 - i * 5), 16'h0,
                16'hA5C3 ^ 16'(i * 16'h1357), 1'b0);
      run_frame(1'b0, 5'(i * 11 + 1), 5'(i * 3), 16'h3C5A + 16'(i * 16'h0F0F),
                16'h0, 1'b0);
    end
    run_frame(1'b1, 5'h1F, 5'h1F, 16'h0, 16'hFFFF, 1'b0);
    run_frame(1'b1, 5'h00, 5'h00, 16'h0, 16'h0000, 1'b0);
    run_frame(1'b0, 5'h00, 5'h1F, 16'hFFFF, 16'h0, 1'b0);
    run_frame(1'b0, 5'h15, 5'h0A, 16'h8001, 16'h0, 1'b1);
    run_frame(1'b1, 5'h0A, 5'h15, 16'h0, 16'h8001, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule